// File: doc/BRIEF.md
# Forced-Interrupt Condition Controller

This block serves the forced-interrupt command class of a floppy disk controller. When the host writes a command byte whose upper nibble is `0xD`, the block asks the command sequencer to abort whatever it is running. The abort is issued only at a safe internal boundary, which means the first cycle in which the sequencer reports that no CRC, compare or similar operation is in progress. The low nibble of the same byte selects the events that will raise the interrupt request line. These are edges of the drive-ready signal, rising edges of the index pulse, or an immediate interrupt.

INTRQ is a sticky flag. Status reads and command writes leave it alone, except that a forced interrupt with an all-zero condition nibble (`0xD0`) sets up a one-shot release: the next status read or command write then clears the line. After each forced interrupt a guard interval runs. Its length is set by the recording density and the controller clock rate. An ordinary command written inside that interval cancels the forced interrupt's pending abort.

Top module: `fi_intr_ctrl`

## Requirements
- R1: While reset is active and after it is released, `intrq`, `abort_req` and `busy_clr` are low.
- R2: A command write with `cmd_data[7:4] = 4'hD` is a forced interrupt, accepted whatever the sequencer state. Any other byte is an ordinary command and produces no abort request.
- R3: After a forced interrupt is sampled at clock edge E, `abort_req` is high for exactly the first cycle after E in which `alu_busy` is low, and stays low while `alu_busy` is high. `busy_clr` is high for the one cycle after `abort_req`.
- R4: The condition bits in `cmd_data[3:0]` are arm bits. Bit 0 arms a ready low-to-high edge, bit 1 a ready high-to-low edge, bit 2 every index rising edge. An event raises `intrq` only when its bit is armed.
- R5: Several arm bits may be set at once, and any one of the armed events raises `intrq`.
- R6: `drv_ready` and `idx_pulse` each pass through a two-flop synchronizer. A change applied before clock edge E0 shows on `intrq` after edge E2 and not before.
- R7: Once high, `intrq` stays high through status reads and command writes, unless a release is pending.
- R8: `0xD0` arms no condition and raises no interrupt, but still requests an abort. It makes a release pending, so the next status read or command write clears `intrq` and consumes the release.
- R9: Bit 3 (immediate) raises `intrq` in the cycle after the write. If that same write consumes a pending release, the set wins and `intrq` stays high.
- R10: At each forced interrupt the guard interval is loaded with G cycles (`GUARD_BASE_CYC`) in double density (`dbl_density` = 1) or 2G in single density. The value is doubled again when `slow_clk` = 1.
- R11: An ordinary command sampled at any of the edges E+1 through E+L (L = guard length) cancels the pending abort. One sampled at E+L+1 or later does not.
- R12: Any ordinary command write disarms the ready and index conditions. A new forced interrupt replaces the armed set with its own bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command byte |
| stat_rd | input | 1 | Status register read strobe |
| drv_ready | input | 1 | Drive ready level, asynchronous |
| idx_pulse | input | 1 | Index pulse, asynchronous |
| dbl_density | input | 1 | 1 = double density, 0 = single density |
| slow_clk | input | 1 | 1 = controller runs at the slower clock rate |
| alu_busy | input | 1 | Sequencer mid-operation (CRC, compare) |
| abort_req | output | 1 | One-cycle request to terminate the running command |
| busy_clr | output | 1 | One-cycle request to clear the busy status bit |
| intrq | output | 1 | Interrupt request |

## Verification
Clearing and setting of INTRQ can happen in the same cycle. One case is a `0xD0` followed directly by `0xD8`: the second write both consumes the release and asserts the immediate interrupt. The bench expects the line to stay high, and expects a later status read to leave it high because the release is used up. A second collision is an ordinary command landing on the last edge of the guard interval while the abort is held back by `alu_busy`. This is probed at the exact edge and at the edge after it, in all four density and clock-rate settings. The random phase toggles ready, pulses index and issues status reads against random arm masks, and compares INTRQ with a bench model after each step.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam logic [3:0] FI_OPCODE = 4'hD;

  typedef struct packed {
    logic immed;
    logic idx_rise;
    logic rdy_fall;
    logic rdy_rise;
  } fi_cond_t;

  function automatic logic is_forced(input logic [7:0] b);
    return b[7:4] == FI_OPCODE;
  endfunction
endpackage

// File: rtl/fi_sync_edge.sv
module fi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_n;
  logic              prev_q, prev_n;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_n = din;
    end else begin : g_many
      always_comb sync_n = {sync_q[STAGES-2:0], din};
    end
  endgenerate

  always_comb prev_n = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= prev_n;
    end
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/fi_guard_timer.sv
module fi_guard_timer #(
  parameter int GUARD_BASE_CYC = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dbl_density,
  input  logic slow_clk,
  output logic active
);
  localparam int CMAX = GUARD_BASE_CYC * 4;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LEN_1X = CW'(GUARD_BASE_CYC);
  localparam logic [CW-1:0] LEN_2X = CW'(GUARD_BASE_CYC * 2);
  localparam logic [CW-1:0] LEN_4X = CW'(CMAX);

  logic [CW-1:0] cnt_q, cnt_n, load_val;

  always_comb begin
    unique case ({dbl_density, slow_clk})
      2'b10:   load_val = LEN_1X;
      2'b00:   load_val = LEN_2X;
      2'b11:   load_val = LEN_2X;
      default: load_val = LEN_4X;
    endcase
  end

  always_comb begin
    cnt_n = cnt_q;
    if (load)             cnt_n = load_val;
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign active = cnt_q != '0;

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_4X);
  assert_load_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/fi_abort_ctl.sv
module fi_abort_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fi_wr,
  input  logic cancel,
  input  logic alu_busy,
  output logic abort_req,
  output logic busy_clr
);
  logic pending_q, pending_n;
  logic bclr_q, bclr_n;
  logic fire;

  assign fire = pending_q & ~alu_busy;

  always_comb begin
    pending_n = pending_q;
    if (fi_wr)       pending_n = 1'b1;
    else if (cancel) pending_n = 1'b0;
    else if (fire)   pending_n = 1'b0;
    bclr_n = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      bclr_q    <= 1'b0;
    end else begin
      pending_q <= pending_n;
      bclr_q    <= bclr_n;
    end
  end

  assign abort_req = fire;
  assign busy_clr  = bclr_q;

  assert_clr_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> busy_clr);
  assert_hold_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && alu_busy && !cancel) |=> pending_q);
  assert_cancel_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !fi_wr) |=> !abort_req);
endmodule

// File: rtl/fi_irq_core.sv
module fi_irq_core
  import fi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fi_wr,
  input  logic       other_wr,
  input  fi_cond_t   cond_in,
  input  logic       stat_rd,
  input  logic       rdy_rise,
  input  logic       rdy_fall,
  input  logic       idx_rise,
  output logic       intrq
);
  logic [2:0] mask_q, mask_n;
  logic       irq_q, irq_n;
  logic       rel_q, rel_n;
  logic       evt, clr, any_wr, is_d0;

  assign any_wr = fi_wr | other_wr;
  assign is_d0  = fi_wr & (cond_in == '0);
  assign clr    = rel_q & (stat_rd | any_wr);

  always_comb begin
    evt = (mask_q[0] & rdy_rise) | (mask_q[1] & rdy_fall) |
          (mask_q[2] & idx_rise) | (fi_wr & cond_in.immed);

    mask_n = mask_q;
    if (fi_wr)         mask_n = {cond_in.idx_rise, cond_in.rdy_fall, cond_in.rdy_rise};
    else if (other_wr) mask_n = '0;

    irq_n = evt | (irq_q & ~clr);

    rel_n = rel_q;
    if (is_d0)    rel_n = 1'b1;
    else if (clr) rel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      irq_q  <= irq_n;
      rel_q  <= rel_n;
    end
  end

  assign intrq = irq_q;

  assert_rise_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(mask_q != '0) || $past(fi_wr && cond_in.immed)));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !rel_q) |=> irq_q);
  assert_immed_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fi_wr && cond_in.immed) |=> irq_q);
endmodule

// File: rtl/fi_intr_ctrl.sv
module fi_intr_ctrl
  import fi_pkg::*;
#(
  parameter int GUARD_BASE_CYC = 1600,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_data,
  input  logic       stat_rd,
  input  logic       drv_ready,
  input  logic       idx_pulse,
  input  logic       dbl_density,
  input  logic       slow_clk,
  input  logic       alu_busy,
  output logic       abort_req,
  output logic       busy_clr,
  output logic       intrq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       fi_wr, other_wr, guard_on, cancel;
  logic [1:0] async_in, ev_rise, ev_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign fi_wr    = cmd_wr & is_forced(cmd_data);
  assign other_wr = cmd_wr & ~is_forced(cmd_data);
  assign cancel   = other_wr & guard_on;

  assign async_in = {idx_pulse, drv_ready};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_sync
      fi_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
        .clk  (clk),
        .rst_n(rst_int_n),
        .din  (async_in[i]),
        .rise (ev_rise[i]),
        .fall (ev_fall[i])
      );
    end
  endgenerate

  fi_guard_timer #(.GUARD_BASE_CYC(GUARD_BASE_CYC)) u_guard (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (fi_wr),
    .dbl_density(dbl_density),
    .slow_clk   (slow_clk),
    .active     (guard_on)
  );

  fi_abort_ctl u_abort (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fi_wr    (fi_wr),
    .cancel   (cancel),
    .alu_busy (alu_busy),
    .abort_req(abort_req),
    .busy_clr (busy_clr)
  );

  fi_irq_core u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fi_wr   (fi_wr),
    .other_wr(other_wr),
    .cond_in (fi_cond_t'(cmd_data[3:0])),
    .stat_rd (stat_rd),
    .rdy_rise(ev_rise[0]),
    .rdy_fall(ev_fall[0]),
    .idx_rise(ev_rise[1]),
    .intrq   (intrq)
  );

  logic unused_idx_fall;
  assign unused_idx_fall = ev_fall[1];

  assert_busy_clr_idle_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_clr && !$past(abort_req)) |-> 1'b0);
endmodule

// File: tb/tb_fi_intr_ctrl.sv
`timescale 1ns/1ps
module tb_fi_intr_ctrl;
  localparam int G = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic stat_rd = 1'b0;
  logic drv_ready = 1'b0;
  logic idx_pulse = 1'b0;
  logic dbl_density = 1'b1;
  logic slow_clk = 1'b0;
  logic alu_busy = 1'b0;
  logic abort_req, busy_clr, intrq;

  int total = 0;
  int bad = 0;
  int n_abort = 0;
  bit done = 1'b0;

  fi_intr_ctrl #(.GUARD_BASE_CYC(G)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .stat_rd(stat_rd), .drv_ready(drv_ready), .idx_pulse(idx_pulse),
    .dbl_density(dbl_density), .slow_clk(slow_clk), .alu_busy(alu_busy),
    .abort_req(abort_req), .busy_clr(busy_clr), .intrq(intrq));

  always #2.5 clk = ~clk;

  always @(posedge clk) if (abort_req) n_abort++;

  function automatic int guard_len(input logic dd, input logic sl);
    int l;
    l = dd ? G : 2 * G;
    if (sl) l = l * 2;
    return l;
  endfunction

  function automatic logic ready_hits(input logic [2:0] m, input logic old_lvl);
    return (m[0] && !old_lvl) || (m[1] && old_lvl);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [7:0] b);
    cmd_wr = 1'b1; cmd_data = b;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic do_rd();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic arm(input logic [3:0] m);
    do_cmd(8'hD0);
    do_cmd({4'hD, m});
  endtask

  task automatic pulse_idx();
    idx_pulse = 1'b1; cyc(2);
    idx_pulse = 1'b0; cyc(3);
  endtask

  task automatic guard_probe(input logic dd, input logic sl, input int k,
                             input int exp_abort, input string tag);
    alu_busy = 1'b1; dbl_density = dd; slow_clk = sl;
    cyc(1);
    do_cmd(8'hD0);
    n_abort = 0;
    repeat (k - 1) @(negedge clk);
    do_cmd(8'h20);
    alu_busy = 1'b0;
    cyc(3);
    chk(tag, n_abort, exp_abort);
    dbl_density = 1'b1; slow_clk = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] m;
    logic       exp_irq;
    void'($urandom(32'h5EED));
    cyc(3);
    chk("R1 intrq in reset", intrq, 0);
    chk("R1 abort in reset", abort_req, 0);
    chk("R1 busy_clr in reset", busy_clr, 0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1 intrq after reset", intrq, 0);
    chk("R1 abort after reset", abort_req, 0);

    // R2: ordinary command gives no abort
    n_abort = 0;
    do_cmd(8'h5A); cyc(3);
    chk("R2 ordinary no abort", n_abort, 0);
    do_cmd(8'hC4); cyc(3);
    chk("R2 0xC4 no abort", n_abort, 0);

    // R3: abort waits for alu idle, then busy_clr
    alu_busy = 1'b1;
    do_cmd(8'hD0);
    n_abort = 0;
    cyc(5);
    chk("R3 held while busy", n_abort, 0);
    alu_busy = 1'b0; #1;
    chk("R3 abort when idle", abort_req, 1);
    chk("R3 busy_clr not yet", busy_clr, 0);
    @(negedge clk);
    chk("R3 abort one cycle", abort_req, 0);
    chk("R3 busy_clr follows", busy_clr, 1);
    @(negedge clk);
    chk("R3 busy_clr one cycle", busy_clr, 0);
    do_cmd(8'hD0);
    chk("R2 forced accepted idle", abort_req, 1);
    cyc(3);

    // R8: D0 arms nothing, no interrupt
    do_cmd(8'hD0); cyc(4);
    drv_ready = 1'b1; cyc(4); pulse_idx();
    drv_ready = 1'b0; cyc(4);
    chk("R8 D0 no intrq", intrq, 0);

    // R6: synchronizer latency
    arm(4'h1);
    chk("R6 clean before", intrq, 0);
    drv_ready = 1'b1;
    @(negedge clk); chk("R6 after E0", intrq, 0);
    @(negedge clk); chk("R6 after E1", intrq, 0);
    @(negedge clk); chk("R6 after E2", intrq, 1);
    cyc(3);

    // R4: unarmed events ignored
    arm(4'h1);
    drv_ready = 1'b0; cyc(4); pulse_idx();
    chk("R4 unarmed fall/index", intrq, 0);
    arm(4'h2);
    drv_ready = 1'b1; cyc(4);
    chk("R4 rise unarmed for I1", intrq, 0);
    drv_ready = 1'b0; cyc(4);
    chk("R4 I1 fall", intrq, 1);

    // R5: OR of conditions
    arm(4'h6); pulse_idx();
    chk("R5 D6 index", intrq, 1);
    drv_ready = 1'b1; cyc(4);
    arm(4'h6);
    drv_ready = 1'b0; cyc(4);
    chk("R5 D6 ready fall", intrq, 1);

    // R12: disarm and replace
    arm(4'h4);
    do_cmd(8'h10); cyc(2); pulse_idx();
    chk("R12 ordinary disarms", intrq, 0);
    arm(4'h4);
    do_cmd(8'hD1); pulse_idx();
    chk("R12 replaced no index", intrq, 0);
    drv_ready = 1'b1; cyc(4);
    chk("R12 replaced ready rise", intrq, 1);
    drv_ready = 1'b0; cyc(4);

    // R9/R7/R8: immediate, sticky, release
    do_cmd(8'hD0); do_rd();
    chk("R8 release clears", intrq, 0);
    do_cmd(8'hD8);
    chk("R9 immediate next cycle", intrq, 1);
    do_rd();
    chk("R7 read keeps", intrq, 1);
    do_cmd(8'h30);
    chk("R7 write keeps", intrq, 1);
    do_cmd(8'hD0);
    chk("R8 D0 itself keeps", intrq, 1);
    do_rd();
    chk("R8 read after D0 clears", intrq, 0);
    do_cmd(8'hD8);
    do_cmd(8'hD0);
    do_cmd(8'hD8);
    chk("R9 set wins over release", intrq, 1);
    do_rd();
    chk("R8 release consumed", intrq, 1);
    do_cmd(8'hD0); do_cmd(8'h40);
    chk("R8 write after D0 clears", intrq, 0);
    cyc(2);

    // R10/R11: guard boundaries in all modes
    for (int md = 0; md < 4; md++) begin
      logic dd, sl;
      int   len;
      dd = md[0]; sl = md[1];
      len = guard_len(dd, sl);
      guard_probe(dd, sl, len, 0, "R11 R10 cancel on last guard edge");
      guard_probe(dd, sl, len + 1, 1, "R11 R10 no cancel after guard");
    end
    guard_probe(1'b1, 1'b0, 1, 0, "R11 cancel first edge");

    // Random phase: R4 R5 model check
    for (int it = 0; it < 30; it++) begin
      m = 3'($urandom % 8);
      arm({1'b0, m});
      exp_irq = 1'b0;
      chk("R4 random arm clean", intrq, 0);
      for (int op = 0; op < 8; op++) begin
        int sel;
        sel = $urandom % 3;
        if (sel == 0) begin
          if (ready_hits(m, drv_ready)) exp_irq = 1'b1;
          drv_ready = ~drv_ready;
          cyc(4);
        end else if (sel == 1) begin
          if (m[2]) exp_irq = 1'b1;
          pulse_idx();
        end else begin
          do_rd(); cyc(1);
        end
        chk("R5 R4 random intrq", intrq, exp_irq);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule